// File: doc/BRIEF.md
# Vectored Interrupt Dispatch Unit

This block sits between a set of peripheral interrupt sources and a small CPU core. It owns three pieces of state. The pending-request register collects one bit per source. The enable mask register selects which sources may interrupt. A single master-enable bit gates all dispatch. Both registers can be read and written over the core's byte-wide data bus. Peripherals set request bits with single-cycle pulses.

When the core reaches an instruction boundary, it raises a boundary strobe. If the master enable is set, at least one request is both pending and unmasked, and no earlier dispatch is still waiting to be acknowledged, the block does four things:

- picks the lowest-numbered such source;
- clears that request bit;
- drops the master enable;
- emits a one-cycle take pulse carrying the vector address.

The core then pushes its return address and jumps to that vector. It signals the end of the push with an acknowledge. The core also forwards the enable, disable and return-from-interrupt commands, which drive the master enable. Instruction decode and the stack itself belong to the core.

Top module: `idu_dispatch`

## Requirements
- R1: After reset the request register is 0, the mask register is 0x00, the master enable is 0, and take and busy are low. A read of the request register returns 0xE0, because bits 7..5 always read as 1.
- R2: A bus write to address 0xFF0F loads request bits 4..0 from write-data bits 4..0. A write to 0xFFFF loads all 8 mask bits. Reads of those addresses return the register contents. Any other address reads 0x00 and a write to it changes neither register.
- R3: A high bit on the source-pulse input sets the matching request bit at the next clock edge. The set wins over a bus write in the same cycle that would clear the bit.
- R4: A dispatch starts when all of the following hold in one cycle: boundary is high, the master enable is 1, busy is 0, and (request AND mask bits 4..0) is non-zero. Take is then high for exactly the one following cycle.
- R5: Among the eligible sources, the lowest bit index wins. The vector is 0x0040 + 8 × index: bit 0 gives 0x0040, bit 1 gives 0x0048, bit 2 gives 0x0050, bit 3 gives 0x0058 and bit 4 gives 0x0060.
- R6: A dispatch clears only the serviced request bit and clears the master enable. The master enable stays cleared even if an enable or return command arrives in the same cycle.
- R7: The enable command and the return-from-interrupt command set the master enable. The disable command clears it, and the disable command wins if it arrives together with an enable command.
- R8: From the take pulse until the push-done acknowledge, busy is high and no further take occurs. The acknowledge clears busy at the next clock edge.
- R9: With the master enable at 0, or with every pending bit masked, a boundary strobe produces no take and the request bits remain set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_pulse_i | input | 5 | Per-source request set pulses |
| bus_wr_i | input | 1 | Bus write strobe |
| bus_addr_i | input | 16 | Bus address |
| bus_wdata_i | input | 8 | Bus write data |
| bus_rdata_o | output | 8 | Bus read data (combinational from address) |
| boundary_i | input | 1 | Core is between instructions |
| cmd_ei_i | input | 1 | Enable-interrupts command |
| cmd_di_i | input | 1 | Disable-interrupts command |
| cmd_reti_i | input | 1 | Return-from-interrupt command |
| push_done_i | input | 1 | Core finished pushing the return address |
| take_o | output | 1 | One-cycle dispatch pulse |
| take_vec_o | output | 16 | Vector address, valid with take |
| ime_o | output | 1 | Master enable state |
| busy_o | output | 1 | Dispatch issued, acknowledge outstanding |

## Verification
The assertions assume that the core acknowledges a dispatch only after it has seen take. They also assume that push_done is never raised while busy is low. The stimulus holds to this: push_done is pulsed only after a take has been observed and busy has been checked high.

The properties on source pulses assume those pulses are single-cycle events. The bench drives them as one-cycle strobes. It never pulses a source in the same cycle as a dispatch of that same source, so the check on the acknowledged bit stays unambiguous.

// File: rtl/idu_pkg.sv
package idu_pkg;
    localparam int IDU_NUM_SRC    = 5;
    localparam int IDU_DATA_W     = 8;
    localparam int IDU_ADDR_W     = 16;
    localparam int IDU_VEC_STRIDE = 8;
    localparam logic [15:0] IDU_FLAG_ADDR = 16'hFF0F;
    localparam logic [15:0] IDU_MASK_ADDR = 16'hFFFF;
    localparam logic [15:0] IDU_VEC_BASE  = 16'h0040;
endpackage

// File: rtl/idu_prio_sel.sv
module idu_prio_sel #(
    parameter int N     = 5,
    parameter int IDX_W = 3
) (
    input  logic [N-1:0]     req_i,
    output logic [N-1:0]     grant_o,
    output logic [IDX_W-1:0] idx_o,
    output logic             any_o
);
    // seen[k] is high when any request below index k is present
    logic [N:0] seen;
    assign seen[0] = 1'b0;

    for (genvar g = 0; g < N; g++) begin : g_chain
        assign grant_o[g]  = req_i[g] & ~seen[g];
        assign seen[g + 1] = seen[g] | req_i[g];
    end

    assign any_o = seen[N];

    always_comb begin
        idx_o = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (grant_o[i]) idx_o = IDX_W'(i);
        end
    end
endmodule

// File: rtl/idu_vec_gen.sv
module idu_vec_gen #(
    parameter int                IDX_W      = 3,
    parameter int                ADDR_W     = 16,
    parameter logic [ADDR_W-1:0] VEC_BASE   = 16'h0040,
    parameter int                VEC_STRIDE = 8
) (
    input  logic [IDX_W-1:0]  idx_i,
    output logic [ADDR_W-1:0] vec_o
);
    localparam logic [ADDR_W-1:0] STRIDE = ADDR_W'(VEC_STRIDE);

    always_comb begin
        vec_o = VEC_BASE + (ADDR_W'(idx_i) * STRIDE);
    end
endmodule

// File: rtl/idu_dispatch.sv
module idu_dispatch
    import idu_pkg::*;
#(
    parameter int                NUM_SRC    = IDU_NUM_SRC,
    parameter int                DATA_W     = IDU_DATA_W,
    parameter int                ADDR_W     = IDU_ADDR_W,
    parameter logic [ADDR_W-1:0] FLAG_ADDR  = IDU_FLAG_ADDR,
    parameter logic [ADDR_W-1:0] MASK_ADDR  = IDU_MASK_ADDR,
    parameter logic [ADDR_W-1:0] VEC_BASE   = IDU_VEC_BASE,
    parameter int                VEC_STRIDE = IDU_VEC_STRIDE
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] src_pulse_i,
    input  logic               bus_wr_i,
    input  logic [ADDR_W-1:0]  bus_addr_i,
    input  logic [DATA_W-1:0]  bus_wdata_i,
    output logic [DATA_W-1:0]  bus_rdata_o,
    input  logic               boundary_i,
    input  logic               cmd_ei_i,
    input  logic               cmd_di_i,
    input  logic               cmd_reti_i,
    input  logic               push_done_i,
    output logic               take_o,
    output logic [ADDR_W-1:0]  take_vec_o,
    output logic               ime_o,
    output logic               busy_o
);
    localparam int IDX_W = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1;
    localparam logic [ADDR_W-1:0] VEC_LAST = VEC_BASE + ADDR_W'(VEC_STRIDE * (NUM_SRC - 1));

    typedef struct packed {
        logic [NUM_SRC-1:0] flags;
        logic [DATA_W-1:0]  mask;
        logic               ime;
        logic               busy;
        logic               take;
        logic [ADDR_W-1:0]  vec;
    } state_t;

    state_t st_q, st_d;

    logic [NUM_SRC-1:0] pending, grant;
    logic [IDX_W-1:0]   grant_idx;
    logic               any_pend;
    logic [ADDR_W-1:0]  vec_calc;
    logic               wr_flag, wr_mask, fire;
    logic [NUM_SRC-1:0] flags_base;

    assign pending = st_q.flags & st_q.mask[NUM_SRC-1:0];

    idu_prio_sel #(.N(NUM_SRC), .IDX_W(IDX_W)) u_sel (
        .req_i   (pending),
        .grant_o (grant),
        .idx_o   (grant_idx),
        .any_o   (any_pend)
    );

    idu_vec_gen #(
        .IDX_W(IDX_W), .ADDR_W(ADDR_W), .VEC_BASE(VEC_BASE), .VEC_STRIDE(VEC_STRIDE)
    ) u_vec (
        .idx_i (grant_idx),
        .vec_o (vec_calc)
    );

    always_comb begin
        st_d       = st_q;
        st_d.take  = 1'b0;
        wr_flag    = bus_wr_i && (bus_addr_i == FLAG_ADDR);
        wr_mask    = bus_wr_i && (bus_addr_i == MASK_ADDR);
        fire       = boundary_i && st_q.ime && !st_q.busy && any_pend;

        if (wr_mask) st_d.mask = bus_wdata_i;

        flags_base = wr_flag ? bus_wdata_i[NUM_SRC-1:0] : st_q.flags;
        if (fire) flags_base = flags_base & ~grant;
        // a fresh source event overrides both write and acknowledge
        st_d.flags = flags_base | src_pulse_i;

        if (cmd_ei_i || cmd_reti_i) st_d.ime = 1'b1;
        if (cmd_di_i)               st_d.ime = 1'b0;

        if (push_done_i) st_d.busy = 1'b0;

        if (fire) begin
            st_d.ime  = 1'b0;
            st_d.busy = 1'b1;
            st_d.take = 1'b1;
            st_d.vec  = vec_calc;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        bus_rdata_o = '0;
        if (bus_addr_i == FLAG_ADDR) begin
            bus_rdata_o                = '1;
            bus_rdata_o[NUM_SRC-1:0]   = st_q.flags;
        end else if (bus_addr_i == MASK_ADDR) begin
            bus_rdata_o = st_q.mask;
        end
    end

    assign take_o     = st_q.take;
    assign take_vec_o = st_q.vec;
    assign ime_o      = st_q.ime;
    assign busy_o     = st_q.busy;

    // ---------------- assertions ----------------
    a_r4_take_single: assert property (@(posedge clk) disable iff (!rst_n)
        take_o |=> !take_o);

    a_r4_take_needs_ime: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(take_o) |-> $past(ime_o) && !$past(busy_o));

    a_r6_take_drops_ime: assert property (@(posedge clk) disable iff (!rst_n)
        take_o |-> !ime_o && busy_o);

    a_r8_hold_while_busy: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |=> !take_o);

    a_r3_pulse_sets: assert property (@(posedge clk) disable iff (!rst_n)
        (|src_pulse_i) |=> ((st_q.flags & $past(src_pulse_i)) == $past(src_pulse_i)));

    a_r5_vec_range: assert property (@(posedge clk) disable iff (!rst_n)
        take_o |-> (take_vec_o >= VEC_BASE) && (take_vec_o <= VEC_LAST));
endmodule

// File: tb/sim_idu_dispatch.sv
module sim_idu_dispatch;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [4:0]  src_pulse = '0;
    logic        bus_wr = 1'b0;
    logic [15:0] bus_addr = '0;
    logic [7:0]  bus_wdata = '0;
    logic [7:0]  bus_rdata;
    logic        boundary = 1'b0, cmd_ei = 1'b0, cmd_di = 1'b0, cmd_reti = 1'b0;
    logic        push_done = 1'b0;
    logic        take;
    logic [15:0] take_vec;
    logic        ime, busy;

    int checks = 0;
    int errors = 0;
    logic [15:0] exp_q[$];

    always #2 clk = ~clk;

    idu_dispatch u0 (
        .clk(clk), .rst_n(rst_n), .src_pulse_i(src_pulse),
        .bus_wr_i(bus_wr), .bus_addr_i(bus_addr), .bus_wdata_i(bus_wdata),
        .bus_rdata_o(bus_rdata), .boundary_i(boundary),
        .cmd_ei_i(cmd_ei), .cmd_di_i(cmd_di), .cmd_reti_i(cmd_reti),
        .push_done_i(push_done), .take_o(take), .take_vec_o(take_vec),
        .ime_o(ime), .busy_o(busy)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // scoreboard monitor
    initial begin
        forever begin
            @(negedge clk);
            if (take) begin
                checks++;
                if (exp_q.size() == 0) begin
                    errors++;
                    $display("FAIL R4 unexpected take actual=%0h expected=none", take_vec);
                end else begin
                    logic [15:0] e;
                    e = exp_q.pop_front();
                    if (e != take_vec) begin
                        errors++;
                        $display("FAIL R5 vector actual=%0h expected=%0h", take_vec, e);
                    end
                end
            end
        end
    end

    initial begin
        #400000;
        errors++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    task automatic bus_write(input logic [15:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic bus_read_chk(input logic [15:0] a, input logic [7:0] e, input string req);
        @(negedge clk);
        bus_addr = a;
        #1;
        check(bus_rdata == e, req, bus_rdata, e);
    endtask

    task automatic cmd(input bit ei, input bit di, input bit reti);
        @(negedge clk);
        cmd_ei = ei; cmd_di = di; cmd_reti = reti;
        @(negedge clk);
        cmd_ei = 1'b0; cmd_di = 1'b0; cmd_reti = 1'b0;
    endtask

    // boundary strobe; expect_take pushes the expected vector for the monitor
    task automatic strobe(input bit expect_take, input logic [15:0] v, input string req);
        @(negedge clk);
        if (expect_take) exp_q.push_back(v);
        boundary = 1'b1;
        @(negedge clk);
        boundary = 1'b0;
        check(take == expect_take, req, take, expect_take);
    endtask

    task automatic ack();
        @(negedge clk);
        push_done = 1'b1;
        @(negedge clk);
        push_done = 1'b0;
        check(busy == 1'b0, "R8 busy cleared", busy, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        bus_read_chk(16'hFF0F, 8'hE0, "R1 flags reset");
        bus_read_chk(16'hFFFF, 8'h00, "R1 mask reset");
        check(ime == 0 && take == 0 && busy == 0, "R1 outputs reset", {ime, take, busy}, 0);

        // R2 register access
        bus_write(16'hFFFF, 8'hA5);
        bus_read_chk(16'hFFFF, 8'hA5, "R2 mask rw");
        bus_write(16'hFF0F, 8'h1F);
        bus_read_chk(16'hFF0F, 8'hFF, "R2 flags rw");
        bus_write(16'hFF0F, 8'h00);
        bus_read_chk(16'hFF0F, 8'hE0, "R2 flags clear");
        bus_write(16'hC000, 8'h1F);
        bus_read_chk(16'hC000, 8'h00, "R2 other addr reads 0");
        bus_read_chk(16'hFF0F, 8'hE0, "R2 other addr write ignored flags");
        bus_read_chk(16'hFFFF, 8'hA5, "R2 other addr write ignored mask");

        // R3 pulse sets bit, wins over clearing write
        @(negedge clk); src_pulse = 5'b00100;
        @(negedge clk); src_pulse = '0;
        bus_read_chk(16'hFF0F, 8'hE4, "R3 pulse sets");
        @(negedge clk);
        src_pulse = 5'b01000; bus_wr = 1'b1; bus_addr = 16'hFF0F; bus_wdata = 8'h00;
        @(negedge clk);
        src_pulse = '0; bus_wr = 1'b0;
        bus_read_chk(16'hFF0F, 8'hE8, "R3 set beats write");

        // R9 no dispatch when disabled or masked
        bus_write(16'hFF0F, 8'h03);
        bus_write(16'hFFFF, 8'h03);
        strobe(1'b0, 16'h0, "R9 ime off no take");
        bus_read_chk(16'hFF0F, 8'hE3, "R9 flags kept (ime off)");
        cmd(1, 0, 0);
        bus_write(16'hFFFF, 8'h00);
        strobe(1'b0, 16'h0, "R9 masked no take");
        bus_read_chk(16'hFF0F, 8'hE3, "R9 flags kept (masked)");

        // R4 R5 R6 basic dispatch, vblank first
        bus_write(16'hFFFF, 8'h1F);
        strobe(1'b1, 16'h0040, "R4 dispatch take");
        check(ime == 0, "R6 ime cleared", ime, 0);
        check(busy == 1, "R8 busy set", busy, 1);
        bus_read_chk(16'hFF0F, 8'hE2, "R6 only serviced bit cleared");
        check(take == 0, "R4 take one cycle", take, 0);
        // R8 no take while busy
        cmd(1, 0, 0);
        strobe(1'b0, 16'h0, "R8 no take while busy");
        ack();
        strobe(1'b1, 16'h0048, "R5 status vector");
        bus_read_chk(16'hFF0F, 8'hE0, "R6 second bit cleared");
        ack();

        // R5 priority among eligible only
        bus_write(16'hFF0F, 8'h1C);
        bus_write(16'hFFFF, 8'h18);
        cmd(0, 0, 1);
        check(ime == 1, "R7 reti sets ime", ime, 1);
        strobe(1'b1, 16'h0058, "R5 masked priority");
        bus_read_chk(16'hFF0F, 8'hF4, "R6 others remain");
        ack();

        // R5 each vector
        bus_write(16'hFFFF, 8'h1F);
        for (int i = 0; i < 5; i++) begin
            bus_write(16'hFF0F, 8'(1 << i));
            cmd(1, 0, 0);
            strobe(1'b1, 16'h0040 + 16'(8 * i), "R5 single source vector");
            ack();
        end

        // R7 command priority
        cmd(1, 1, 0);
        check(ime == 0, "R7 di wins over ei", ime, 0);
        cmd(1, 0, 0);
        check(ime == 1, "R7 ei sets", ime, 1);
        cmd(0, 1, 0);
        check(ime == 0, "R7 di clears", ime, 0);

        // R6 dispatch beats simultaneous ei
        cmd(1, 0, 0);
        bus_write(16'hFF0F, 8'h02);
        @(negedge clk);
        exp_q.push_back(16'h0048);
        boundary = 1'b1; cmd_ei = 1'b1;
        @(negedge clk);
        boundary = 1'b0; cmd_ei = 1'b0;
        check(ime == 0, "R6 dispatch beats ei", ime, 0);
        ack();

        repeat (3) @(negedge clk);
        check(exp_q.size() == 0, "R4 all expected takes seen", exp_q.size(), 0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule